// File: doc/BRIEF.md
# Dual-Clock Programmable Almost-Full / Almost-Empty Flag Generator

This block drives the two active-low threshold flags of an asynchronous FIFO whose write side and read side run on unrelated clocks. The write and read pointers come in from their own domains. The block compares the current fill level against two programmable offsets. Almost-full uses the full offset and counts free words. Almost-empty uses the empty offset and counts stored words. The storage array and the loading of the offsets sit outside this block. The offsets are treated as quasi-static.

A timing-mode input is captured while master reset is held. In the registered mode, each flag is a flop in the clock domain that owns it. In the split mode, each flag is set by one clock and released by the other. Almost-full goes active on a write-clock edge and is released on a read-clock edge. Almost-empty goes active on a read-clock edge and is released on a write-clock edge. Pointers that cross a domain boundary are passed as Gray code through a two-stage synchronizer.

Top module: `almost_flag_gen`

## Requirements
- R1: `modeSel` is captured on the clock edges that occur while `mrstN` is low. 1 selects registered mode and 0 selects split mode. Changing `modeSel` after reset has no effect on flag timing.
- R2: In registered mode, `almostFullN` changes only on write-clock rising edges. It goes low on the first write-clock edge after a write that brings free space to the full offset or below. After a read, it stays low for at least the first read-clock edge that follows.
- R3: In registered mode, `almostEmptyN` changes only on read-clock rising edges. It goes low on the first read-clock edge after a read that brings the stored count to the empty offset or below. After a write, it stays low for at least the first write-clock edge that follows.
- R4: In split mode, `almostFullN` goes low on the first write-clock edge after a write that brings free space to the full offset or below. It returns high on the first read-clock edge after a read that raises free space above the offset.
- R5: In split mode, `almostEmptyN` goes low on the first read-clock edge after a read that brings the stored count to the empty offset or below. It returns high on the first write-clock edge after a write that raises the count above the offset.
- R6: With the pointers at rest, `almostFullN` is 0 exactly when DEPTH minus (wrPtr minus rdPtr) is at most `fullOffset`. `almostEmptyN` is 0 exactly when (wrPtr minus rdPtr) is at most `emptyOffset`. Both modes settle to these same values.
- R7: While reset is held and after its release with the pointers unmoved, `almostFullN` is 1 and `almostEmptyN` is 0.
- R8: Pointers are binary, ADDR_W+1 bits wide, and wrap modulo 2*DEPTH. Each pointer advances by at most one per cycle of its own clock. Flags remain correct across pointer wrap.
- R9: A full offset of 0 makes `almostFullN` low only when the FIFO is completely full. An empty offset of 0 makes `almostEmptyN` low only when the FIFO is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write-side clock |
| rdClk | input | 1 | Read-side clock, unrelated to wrClk |
| mrstN | input | 1 | Active-low master reset, asynchronous assert; both clocks must run while it is low |
| modeSel | input | 1 | Flag timing select, captured during reset (1 registered, 0 split) |
| wrPtr | input | ADDR_W+1 | Binary write pointer, in the wrClk domain |
| rdPtr | input | ADDR_W+1 | Binary read pointer, in the rdClk domain |
| fullOffset | input | ADDR_W | Free-word threshold for almost-full |
| emptyOffset | input | ADDR_W | Stored-word threshold for almost-empty |
| almostFullN | output | 1 | Active-low almost-full flag |
| almostEmptyN | output | 1 | Active-low almost-empty flag |

## Verification
The hardest situation to reach from the ports is the window right after the opposite-domain pointer has moved. In that window, registered mode must still show the old flag value, while split mode must already have released it. The stimulus first fills or drains the FIFO to exactly one word from a threshold and lets both domains settle. It then moves the other domain's pointer by a single step and samples the flag just after the very next edge of that clock. That edge falls before any synchronized copy can reach the owning domain, so the two modes must give opposite answers. The bench also flips `modeSel` after reset before this probe, to show that the captured mode stays in force.

// File: rtl/afg_pkg.sv
package afg_pkg;

  // Threshold compare strobes, one pair per clock domain.
  typedef struct packed {
    logic fullWr;   // free space at/below full offset, write-side view
    logic emptyWr;  // count at/below empty offset, write-side view
    logic fullRd;   // free space at/below full offset, read-side view
    logic emptyRd;  // count at/below empty offset, read-side view
  } levelCmp_t;

endpackage

// File: rtl/afg_level_path.sv
module afg_level_path
  import afg_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic            wrClk,
  input  logic            rdClk,
  input  logic            mrstN,
  input  logic [ADDR_W:0] wrPtr,
  input  logic [ADDR_W:0] rdPtr,
  input  logic [ADDR_W-1:0] fullOff,
  input  logic [ADDR_W-1:0] emptyOff,
  output levelCmp_t       cmp
);

  localparam int PTR_W = ADDR_W + 1;
  localparam logic [PTR_W-1:0] DEPTH = {1'b1, {ADDR_W{1'b0}}};

  function automatic logic [PTR_W-1:0] toGray(input logic [PTR_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PTR_W-1:0] fromGray(input logic [PTR_W-1:0] g);
    logic [PTR_W-1:0] b;
    b[PTR_W-1] = g[PTR_W-1];
    for (int i = PTR_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [PTR_W-1:0] wrGray, rdGray;
  logic [PTR_W-1:0] rdGraySyncW [SYNC_STAGES];
  logic [PTR_W-1:0] wrGraySyncR [SYNC_STAGES];
  logic [PTR_W-1:0] rdBinW, wrBinR;
  logic [PTR_W-1:0] fillW, freeW, fillR, freeR;

  // Write domain: registered Gray copy of own pointer, synchronizer for the other
  always_ff @(posedge wrClk or negedge mrstN) begin
    if (!mrstN) begin
      wrGray <= '0;
      for (int s = 0; s < SYNC_STAGES; s++) rdGraySyncW[s] <= '0;
    end else begin
      wrGray         <= toGray(wrPtr);
      rdGraySyncW[0] <= rdGray;
      for (int s = 1; s < SYNC_STAGES; s++) rdGraySyncW[s] <= rdGraySyncW[s-1];
    end
  end

  // Read domain: mirror image
  always_ff @(posedge rdClk or negedge mrstN) begin
    if (!mrstN) begin
      rdGray <= '0;
      for (int s = 0; s < SYNC_STAGES; s++) wrGraySyncR[s] <= '0;
    end else begin
      rdGray         <= toGray(rdPtr);
      wrGraySyncR[0] <= wrGray;
      for (int s = 1; s < SYNC_STAGES; s++) wrGraySyncR[s] <= wrGraySyncR[s-1];
    end
  end

  always_comb begin
    rdBinW = fromGray(rdGraySyncW[SYNC_STAGES-1]);
    wrBinR = fromGray(wrGraySyncR[SYNC_STAGES-1]);
    fillW  = wrPtr - rdBinW;
    freeW  = DEPTH - fillW;
    fillR  = wrBinR - rdPtr;
    freeR  = DEPTH - fillR;
    cmp.fullWr  = freeW <= {1'b0, fullOff};
    cmp.emptyWr = fillW <= {1'b0, emptyOff};
    cmp.fullRd  = freeR <= {1'b0, fullOff};
    cmp.emptyRd = fillR <= {1'b0, emptyOff};
  end

  // R8: source-side Gray copy moves by at most one bit per cycle
  assert_gray_step_R8: assert property (@(posedge wrClk) disable iff (!mrstN)
    $onehot0(wrGray ^ $past(wrGray)))
    else $error("write Gray pointer stepped more than one bit");

  // R6: write-side fill view never exceeds the depth
  assert_fill_bound_R6: assert property (@(posedge wrClk) disable iff (!mrstN)
    fillW <= DEPTH)
    else $error("write-side fill view beyond depth");

endmodule

// File: rtl/afg_flag_ctrl.sv
module afg_flag_ctrl
  import afg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      wrClk,
  input  logic      rdClk,
  input  logic      mrstN,
  input  logic      modeSel,
  input  levelCmp_t cmp,
  output logic      almostFullN,
  output logic      almostEmptyN
);

  logic modeW, modeR;            // 1 = registered, 0 = split
  logic afRegW, aeRegR;          // registered-mode flags (active high)
  logic afSet, aeClr;            // write-domain toggles
  logic afClr, aeSet;            // read-domain toggles
  logic afClrInW [SYNC_STAGES];
  logic aeSetInW [SYNC_STAGES];
  logic afSetInR [SYNC_STAGES];
  logic aeClrInR [SYNC_STAGES];
  logic afSeenW, aeSeenW, afSeenR, aeSeenR;

  // Mode capture while reset is held
  always_ff @(posedge wrClk) if (!mrstN) modeW <= modeSel;
  always_ff @(posedge rdClk) if (!mrstN) modeR <= modeSel;

  assign afSeenW = afSet ^ afClrInW[SYNC_STAGES-1];
  assign aeSeenW = aeSetInW[SYNC_STAGES-1] ^ aeClr;
  assign afSeenR = afSetInR[SYNC_STAGES-1] ^ afClr;
  assign aeSeenR = aeSet ^ aeClrInR[SYNC_STAGES-1];

  always_ff @(posedge wrClk or negedge mrstN) begin
    if (!mrstN) begin
      afRegW <= 1'b0;
      afSet  <= 1'b0;
      aeClr  <= 1'b0;
      for (int s = 0; s < SYNC_STAGES; s++) begin
        afClrInW[s] <= 1'b0;
        aeSetInW[s] <= 1'b1;
      end
    end else begin
      afRegW      <= cmp.fullWr;
      afClrInW[0] <= afClr;
      aeSetInW[0] <= aeSet;
      for (int s = 1; s < SYNC_STAGES; s++) begin
        afClrInW[s] <= afClrInW[s-1];
        aeSetInW[s] <= aeSetInW[s-1];
      end
      if (!modeW && cmp.fullWr && !afSeenW)   afSet <= ~afSet;
      if (!modeW && !cmp.emptyWr && aeSeenW)  aeClr <= ~aeClr;
    end
  end

  always_ff @(posedge rdClk or negedge mrstN) begin
    if (!mrstN) begin
      aeRegR <= 1'b1;
      aeSet  <= 1'b1;
      afClr  <= 1'b0;
      for (int s = 0; s < SYNC_STAGES; s++) begin
        afSetInR[s] <= 1'b0;
        aeClrInR[s] <= 1'b0;
      end
    end else begin
      aeRegR      <= cmp.emptyRd;
      afSetInR[0] <= afSet;
      aeClrInR[0] <= aeClr;
      for (int s = 1; s < SYNC_STAGES; s++) begin
        afSetInR[s] <= afSetInR[s-1];
        aeClrInR[s] <= aeClrInR[s-1];
      end
      if (!modeR && cmp.emptyRd && !aeSeenR) aeSet <= ~aeSet;
      if (!modeR && !cmp.fullRd && afSeenR)  afClr <= ~afClr;
    end
  end

  assign almostFullN  = modeW ? ~afRegW : ~(afSet ^ afClr);
  assign almostEmptyN = modeR ? ~aeRegR : ~(aeSet ^ aeClr);

  // R1: registered mode leaves the split-mode toggles idle
  assert_split_idle_R1: assert property (@(posedge wrClk) disable iff (!mrstN)
    modeW |-> $stable(afSet))
    else $error("split toggle moved in registered mode");

  // R2: registered almost-full follows the write-side compare one edge later
  assert_reg_full_R2: assert property (@(posedge wrClk) disable iff (!mrstN)
    (modeW && cmp.fullWr) |=> !almostFullN)
    else $error("registered almost-full missed");

  // R3: registered almost-empty follows the read-side compare one edge later
  assert_reg_empty_R3: assert property (@(posedge rdClk) disable iff (!mrstN)
    (modeR && cmp.emptyRd) |=> !almostEmptyN)
    else $error("registered almost-empty missed");

endmodule

// File: rtl/almost_flag_gen.sv
module almost_flag_gen
  import afg_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              mrstN,
  input  logic              modeSel,
  input  logic [ADDR_W:0]   wrPtr,
  input  logic [ADDR_W:0]   rdPtr,
  input  logic [ADDR_W-1:0] fullOffset,
  input  logic [ADDR_W-1:0] emptyOffset,
  output logic              almostFullN,
  output logic              almostEmptyN
);

  levelCmp_t cmp;

  afg_level_path #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) uPath (
    .wrClk   (wrClk),
    .rdClk   (rdClk),
    .mrstN   (mrstN),
    .wrPtr   (wrPtr),
    .rdPtr   (rdPtr),
    .fullOff (fullOffset),
    .emptyOff(emptyOffset),
    .cmp     (cmp)
  );

  afg_flag_ctrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .wrClk       (wrClk),
    .rdClk       (rdClk),
    .mrstN       (mrstN),
    .modeSel     (modeSel),
    .cmp         (cmp),
    .almostFullN (almostFullN),
    .almostEmptyN(almostEmptyN)
  );

endmodule

// File: tb/tb_almost_flag_gen.sv
`timescale 1ns/100ps
module tb_almost_flag_gen;

  localparam int ADDR_W = 4;
  localparam int NVEC   = 12;

  logic wrClk = 1'b0, rdClk = 1'b0;
  logic mrstN, modeSel;
  logic [ADDR_W:0] wrPtr, rdPtr;
  logic [ADDR_W-1:0] fullOffset, emptyOffset;
  logic almostFullN, almostEmptyN;
  int nChecks = 0, nFails = 0;

  always #10   wrClk = ~wrClk;   // 50 MHz write clock
  always #13.5 rdClk = ~rdClk;   // unrelated read clock

  almost_flag_gen #(.ADDR_W(ADDR_W)) dut (
    .wrClk(wrClk), .rdClk(rdClk), .mrstN(mrstN), .modeSel(modeSel),
    .wrPtr(wrPtr), .rdPtr(rdPtr), .fullOffset(fullOffset),
    .emptyOffset(emptyOffset), .almostFullN(almostFullN),
    .almostEmptyN(almostEmptyN)
  );

  // {writes, reads, expected almostFullN, expected almostEmptyN}; full offset 4, empty offset 3
  localparam logic [11:0] VEC [NVEC] = '{
    {5'd5,  5'd0,  1'b1, 1'b1},   // fill 5
    {5'd7,  5'd0,  1'b0, 1'b1},   // fill 12
    {5'd4,  5'd0,  1'b0, 1'b1},   // fill 16
    {5'd0,  5'd5,  1'b1, 1'b1},   // fill 11
    {5'd0,  5'd8,  1'b1, 1'b0},   // fill 3
    {5'd1,  5'd0,  1'b1, 1'b1},   // fill 4
    {5'd0,  5'd4,  1'b1, 1'b0},   // fill 0
    {5'd11, 5'd0,  1'b1, 1'b1},   // fill 11
    {5'd1,  5'd0,  1'b0, 1'b1},   // fill 12
    {5'd0,  5'd8,  1'b1, 1'b1},   // fill 4
    {5'd10, 5'd0,  1'b0, 1'b1},   // fill 14, pointers wrap
    {5'd0,  5'd14, 1'b1, 1'b0}    // fill 0
  };

  task automatic check(input string tag, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic doWrite();
    @(posedge wrClk); #1 wrPtr = wrPtr + 1'b1;
  endtask

  task automatic doRead();
    @(posedge rdClk); #1 rdPtr = rdPtr + 1'b1;
  endtask

  task automatic writes(input int n);
    for (int i = 0; i < n; i++) doWrite();
  endtask

  task automatic reads(input int n);
    for (int i = 0; i < n; i++) doRead();
  endtask

  task automatic settle();
    repeat (6) @(posedge wrClk);
    repeat (6) @(posedge rdClk);
    #2;
  endtask

  task automatic doReset(input logic mode, input logic [ADDR_W-1:0] m, input logic [ADDR_W-1:0] n);
    mrstN = 1'b0; modeSel = mode; fullOffset = m; emptyOffset = n;
    wrPtr = '0; rdPtr = '0;
    repeat (4) @(posedge wrClk);
    repeat (4) @(posedge rdClk);
    #2;
    check("R7 reset almostFullN", almostFullN, 1'b1);
    check("R7 reset almostEmptyN", almostEmptyN, 1'b0);
    #1 mrstN = 1'b1;
    settle();
    check("R7 post-reset almostFullN", almostFullN, 1'b1);
    check("R7 post-reset almostEmptyN", almostEmptyN, 1'b0);
  endtask

  task automatic runTable(input logic mode);
    doReset(mode, 4'd4, 4'd3);
    for (int v = 0; v < NVEC; v++) begin
      writes(int'(VEC[v][11:7]));
      reads(int'(VEC[v][6:2]));
      settle();
      check($sformatf("R6,R8 vec%0d mode%0b almostFullN", v, mode), almostFullN, VEC[v][1]);
      check($sformatf("R6,R8 vec%0d mode%0b almostEmptyN", v, mode), almostEmptyN, VEC[v][0]);
    end
  endtask

  // One-step probes right after the opposite domain moves
  task automatic runEdges(input logic mode);
    string fTag, eTag;
    fTag = mode ? "R1,R2" : "R1,R4";
    eTag = mode ? "R1,R3" : "R1,R5";
    doReset(mode, 4'd4, 4'd3);
    modeSel = ~mode;                      // must be ignored after reset
    writes(11); settle();
    check({fTag, " fill11 almostFullN"}, almostFullN, 1'b1);
    doWrite(); @(posedge wrClk); #2;
    check({fTag, " assert edge almostFullN"}, almostFullN, 1'b0);
    settle();
    doRead(); @(posedge rdClk); #2;
    check({fTag, " release probe almostFullN"}, almostFullN, mode ? 1'b0 : 1'b1);
    settle();
    check({fTag, " settled almostFullN"}, almostFullN, 1'b1);
    reads(7); settle();
    check({eTag, " fill4 almostEmptyN"}, almostEmptyN, 1'b1);
    doRead(); @(posedge rdClk); #2;
    check({eTag, " assert edge almostEmptyN"}, almostEmptyN, 1'b0);
    settle();
    doWrite(); @(posedge wrClk); #2;
    check({eTag, " release probe almostEmptyN"}, almostEmptyN, mode ? 1'b0 : 1'b1);
    settle();
    check({eTag, " settled almostEmptyN"}, almostEmptyN, 1'b1);
  endtask

  task automatic runBounds(input logic mode);
    doReset(mode, 4'd0, 4'd0);
    writes(15); settle();
    check("R9 fill15 almostFullN", almostFullN, 1'b1);
    check("R9 fill15 almostEmptyN", almostEmptyN, 1'b1);
    writes(1); settle();
    check("R9 fill16 almostFullN", almostFullN, 1'b0);
    reads(15); settle();
    check("R9 fill1 almostFullN", almostFullN, 1'b1);
    check("R9 fill1 almostEmptyN", almostEmptyN, 1'b1);
    reads(1); settle();
    check("R9 fill0 almostEmptyN", almostEmptyN, 1'b0);
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    #3000000;
    nChecks++; nFails++;
    $display("FAIL watchdog (R1..R9 run): actual hung expected finished");
    finishRun();
  end

  initial begin
    mrstN = 1'b1; modeSel = 1'b1; wrPtr = '0; rdPtr = '0;
    fullOffset = '0; emptyOffset = '0;
    #2;
    runTable(1'b1);
    runTable(1'b0);
    runEdges(1'b1);
    runEdges(1'b0);
    runBounds(1'b0);
    runBounds(1'b1);
    finishRun();
  end

endmodule